// File: doc/BRIEF.md
# Card Host Interrupt Status and Mask Register Set

This block holds the interrupt bookkeeping of a memory-card host controller. A 32-bit main status word collects event flags from the command and data engines and from card detection. A 32-bit mask word chooses which of those flags may interrupt the processor. A second, 16-bit status and mask pair does the same job for interrupts raised by the card's own I/O function. Software reaches all four words through a 16-bit register bus. Each 32-bit word takes two consecutive 16-bit addresses, with the low half at the lower address.

Hardware sets a sticky status bit with a one-cycle pulse on its event input. Software acknowledges events by writing a half-word in which the bits to clear are 0 and all other bits are 1. Three status bits are not sticky: signal state, write protect and command busy follow their level inputs directly. A mask bit of 1 blocks its source.

A two-state interrupt machine drives the interrupt output. It has the states IRQ_QUIET and IRQ_RAISED. The transition QUIET to RAISED is taken when any unmasked status bit is set in either pair. The transition RAISED to QUIET is taken when none is set. The output is high in IRQ_RAISED only, so it follows the pending condition one clock later.

Top module: `card_irq_regs`

## Requirements
- R1: After reset the registers read as follows: main status 0x0000 at 0x1C and 0x1E (with all level inputs low), main mask 0x031D at 0x20 and 0x837F at 0x22, card I/O status 0x0000 at 0x36, card I/O mask 0xC007 at 0x38. The irq output is 0.
- R2: A one-cycle pulse on `main_evt[n]` sets sticky main status bit n. The bit stays set after the pulse ends, and a read never clears it. The sticky bits are 0, 2, 3, 4, 16 to 22, 24, 25, 29 and 31.
- R3: A write to 0x1C clears the status bits 15..0 that are written as 0 and leaves those written as 1 unchanged. A write to 0x1E does the same for bits 31..16. A write to one half never changes the other half.
- R4: If an event pulse and a clearing write reach the same status bit in the same cycle, the bit ends set.
- R5: Bit 5 reads `lvl_sig`, bit 7 reads `lvl_wprot` and bit 30 reads `lvl_busy`, in the same cycle as the input. Status writes have no effect on these three bits.
- R6: A write to 0x20 or 0x22 stores the 16-bit data into that half of the mask as written. The other half is untouched, and the value reads back exactly.
- R7: irq is 1 from the clock edge after any status bit with mask 0 (in either pair) becomes 1. It returns to 0 on the clock edge after no such bit remains. A set bit whose mask is 1 never raises irq.
- R8: `io_evt` pulses set card I/O status bits 0, 1, 2, 14 and 15 at 0x36. Writing 0 to one of these bits clears it, and writing 1 leaves it unchanged. The mask at 0x38 gates these bits into irq in the same way as the main pair.
- R9: Reads at any address other than 0x1C, 0x1E, 0x20, 0x22, 0x36 and 0x38 return 0. Writes there change no register.
- R10: Main status bits outside the implemented set always read 0, even while their event inputs pulse. The implemented set is the sticky bits plus 5, 7 and 30.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the 16-bit register bus |
| reg_addr | input | ADDR_W (9) | Byte offset of the half-word being accessed |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data (combinational from reg_addr) |
| main_evt | input | MAIN_W (32) | Event set pulses, one per main status bit |
| io_evt | input | IO_W (16) | Event set pulses, one per card I/O status bit |
| lvl_sig | input | 1 | Signal-state level source |
| lvl_wprot | input | 1 | Write-protect level source |
| lvl_busy | input | 1 | Command-busy level source |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: a 32-bit main pair split into two halves, a 16-bit card I/O pair, a 9-bit offset and the stated reset masks. These defaults put the high half within reach, so the checks cover half-isolation in both directions, both exception flags of the card I/O word, and the command-busy level bit at position 30. Irq timing is checked on both sides of the one-cycle latency, using a sticky source, a level source and a card I/O source.

// File: rtl/card_irq_pkg.sv
package card_irq_pkg;

    localparam int HALF_W = 16;

    // register byte offsets (each 32-bit word spans base and base+2)
    localparam int OFF_MAIN_STAT = 'h1C;
    localparam int OFF_MAIN_MASK = 'h20;
    localparam int OFF_IO_STAT   = 'h36;
    localparam int OFF_IO_MASK   = 'h38;

    // positions of the non-sticky level bits in the main status word
    localparam int POS_SIGNAL = 5;
    localparam int POS_WPROT  = 7;
    localparam int POS_BUSY   = 30;

    typedef enum logic {
        IRQ_QUIET,
        IRQ_RAISED
    } irq_state_e;

endpackage

// File: rtl/card_irq_status.sv
module card_irq_status
    import card_irq_pkg::*;
#(
    parameter int              W     = 32,
    parameter logic [W-1:0]    IMPL  = '1,
    parameter logic [W-1:0]    LEVEL = '0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [W/HALF_W-1:0]   half_wr,
    input  logic [HALF_W-1:0]     wdata,
    input  logic [W-1:0]          hw_set,
    input  logic [W-1:0]          lvl_in,
    output logic [W-1:0]          value
);

    localparam int           NHALF  = W / HALF_W;
    localparam logic [W-1:0] STICKY = IMPL & ~LEVEL;

    logic [W-1:0] sticky_q;
    logic [W-1:0] clr;

    // software clear: a 0 written in a selected half clears that bit
    generate
        for (genvar h = 0; h < NHALF; h++) begin : g_clr
            assign clr[h*HALF_W +: HALF_W] = half_wr[h] ? ~wdata : '0;
        end
    endgenerate

    // a hardware set in the same cycle as a clear wins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sticky_q <= '0;
        end else begin
            sticky_q <= ((sticky_q & ~clr) | hw_set) & STICKY;
        end
    end

    assign value = sticky_q | (lvl_in & LEVEL & IMPL);

endmodule

// File: rtl/card_irq_mask.sv
module card_irq_mask
    import card_irq_pkg::*;
#(
    parameter int           W     = 32,
    parameter logic [W-1:0] RESET = '1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [W/HALF_W-1:0] half_wr,
    input  logic [HALF_W-1:0]   wdata,
    output logic [W-1:0]        value
);

    localparam int NHALF = W / HALF_W;

    generate
        for (genvar h = 0; h < NHALF; h++) begin : g_half
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    value[h*HALF_W +: HALF_W] <= RESET[h*HALF_W +: HALF_W];
                end else if (half_wr[h]) begin
                    value[h*HALF_W +: HALF_W] <= wdata;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/card_irq_fsm.sv
module card_irq_fsm
    import card_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending,
    output logic irq
);

    irq_state_e state_q;
    irq_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IRQ_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:  if (pending)  state_d = IRQ_RAISED;
            IRQ_RAISED: if (!pending) state_d = IRQ_QUIET;
            default:    state_d = IRQ_QUIET;
        endcase
    end

    always_comb begin
        irq = (state_q == IRQ_RAISED);
    end

endmodule

// File: rtl/card_irq_regs.sv
module card_irq_regs
    import card_irq_pkg::*;
#(
    parameter int                 ADDR_W      = 9,
    parameter int                 MAIN_W      = 32,
    parameter int                 IO_W        = 16,
    parameter logic [MAIN_W-1:0]  MAIN_IMPL   = 32'hE37F_00BD,
    parameter logic [MAIN_W-1:0]  MAIN_MASK_R = 32'h837F_031D,
    parameter logic [IO_W-1:0]    IO_IMPL     = 16'hC007,
    parameter logic [IO_W-1:0]    IO_MASK_R   = 16'hC007
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [HALF_W-1:0] reg_wdata,
    output logic [HALF_W-1:0] reg_rdata,
    input  logic [MAIN_W-1:0] main_evt,
    input  logic [IO_W-1:0]   io_evt,
    input  logic              lvl_sig,
    input  logic              lvl_wprot,
    input  logic              lvl_busy,
    output logic              irq
);

    localparam int MAIN_NH = MAIN_W / HALF_W;
    localparam int IO_NH   = IO_W / HALF_W;
    localparam logic [MAIN_W-1:0] MAIN_LEVEL =
        (MAIN_W'(1) << POS_SIGNAL) | (MAIN_W'(1) << POS_WPROT) | (MAIN_W'(1) << POS_BUSY);

    logic [MAIN_NH-1:0] sel_mst, sel_mmk;
    logic [IO_NH-1:0]   sel_ist, sel_imk;
    logic [MAIN_W-1:0]  st_main, mk_main, lvl_vec;
    logic [IO_W-1:0]    st_io, mk_io;
    logic               pending;

    // half-word address decode
    generate
        for (genvar h = 0; h < MAIN_NH; h++) begin : g_main_dec
            assign sel_mst[h] = (reg_addr == ADDR_W'(OFF_MAIN_STAT + 2*h));
            assign sel_mmk[h] = (reg_addr == ADDR_W'(OFF_MAIN_MASK + 2*h));
        end
        for (genvar h = 0; h < IO_NH; h++) begin : g_io_dec
            assign sel_ist[h] = (reg_addr == ADDR_W'(OFF_IO_STAT + 2*h));
            assign sel_imk[h] = (reg_addr == ADDR_W'(OFF_IO_MASK + 2*h));
        end
    endgenerate

    always_comb begin
        lvl_vec             = '0;
        lvl_vec[POS_SIGNAL] = lvl_sig;
        lvl_vec[POS_WPROT]  = lvl_wprot;
        lvl_vec[POS_BUSY]   = lvl_busy;
    end

    card_irq_status #(.W(MAIN_W), .IMPL(MAIN_IMPL), .LEVEL(MAIN_LEVEL)) u_main_st (
        .clk     (clk),
        .rst_n   (rst_n),
        .half_wr (sel_mst & {MAIN_NH{reg_wr}}),
        .wdata   (reg_wdata),
        .hw_set  (main_evt),
        .lvl_in  (lvl_vec),
        .value   (st_main)
    );

    card_irq_mask #(.W(MAIN_W), .RESET(MAIN_MASK_R)) u_main_mk (
        .clk     (clk),
        .rst_n   (rst_n),
        .half_wr (sel_mmk & {MAIN_NH{reg_wr}}),
        .wdata   (reg_wdata),
        .value   (mk_main)
    );

    card_irq_status #(.W(IO_W), .IMPL(IO_IMPL), .LEVEL('0)) u_io_st (
        .clk     (clk),
        .rst_n   (rst_n),
        .half_wr (sel_ist & {IO_NH{reg_wr}}),
        .wdata   (reg_wdata),
        .hw_set  (io_evt),
        .lvl_in  ('0),
        .value   (st_io)
    );

    card_irq_mask #(.W(IO_W), .RESET(IO_MASK_R)) u_io_mk (
        .clk     (clk),
        .rst_n   (rst_n),
        .half_wr (sel_imk & {IO_NH{reg_wr}}),
        .wdata   (reg_wdata),
        .value   (mk_io)
    );

    // read multiplexer: reads have no side effects
    always_comb begin
        reg_rdata = '0;
        for (int h = 0; h < MAIN_NH; h++) begin
            if (sel_mst[h]) reg_rdata = st_main[h*HALF_W +: HALF_W];
            if (sel_mmk[h]) reg_rdata = mk_main[h*HALF_W +: HALF_W];
        end
        for (int h = 0; h < IO_NH; h++) begin
            if (sel_ist[h]) reg_rdata = st_io[h*HALF_W +: HALF_W];
            if (sel_imk[h]) reg_rdata = mk_io[h*HALF_W +: HALF_W];
        end
    end

    assign pending = (|(st_main & ~mk_main)) | (|(st_io & ~mk_io));

    card_irq_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .pending (pending),
        .irq     (irq)
    );

endmodule

// File: rtl/card_irq_checker.sv
module card_irq_checker #(
    parameter int                MAIN_W    = 32,
    parameter int                IO_W      = 16,
    parameter logic [MAIN_W-1:0] MAIN_IMPL = 32'hE37F_00BD
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [MAIN_W-1:0] main_evt,
    input logic [MAIN_W-1:0] st_main,
    input logic [MAIN_W-1:0] mk_main,
    input logic [IO_W-1:0]   st_io,
    input logic [IO_W-1:0]   mk_io,
    input logic              irq
);

    localparam logic [MAIN_W-1:0] STICKY_BITS = MAIN_IMPL & ~MAIN_W'(32'h4000_00A0);

    logic               want_irq;
    logic [MAIN_W-1:0]  evt_sticky;

    assign want_irq   = (|(st_main & ~mk_main)) || (|(st_io & ~mk_io));
    assign evt_sticky = main_evt & STICKY_BITS;

    assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_sticky) |=> ((st_main & $past(evt_sticky)) == $past(evt_sticky)));

    assert_sticky_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr && main_evt == '0) |=> $stable(st_main & STICKY_BITS));

    assert_mask_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr) |=> $stable(mk_main));

    assert_irq_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        want_irq |=> irq);

    assert_irq_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !want_irq |=> !irq);

    always_comb begin
        if (rst_n) begin
            assert_unimpl_zero_R10: assert ((st_main & ~MAIN_IMPL) == '0);
        end
    end

endmodule

bind card_irq_regs card_irq_checker #(
    .MAIN_W    (MAIN_W),
    .IO_W      (IO_W),
    .MAIN_IMPL (MAIN_IMPL)
) u_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .main_evt (main_evt),
    .st_main  (st_main),
    .mk_main  (mk_main),
    .st_io    (st_io),
    .mk_io    (mk_io),
    .irq      (irq)
);

// File: tb/test_card_irq_regs.sv
module test_card_irq_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [8:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [31:0] main_evt = '0;
    logic [15:0] io_evt = '0;
    logic        lvl_sig = 1'b0;
    logic        lvl_wprot = 1'b0;
    logic        lvl_busy = 1'b0;
    logic        irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    card_irq_regs i_card_irq_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .main_evt  (main_evt),
        .io_evt    (io_evt),
        .lvl_sig   (lvl_sig),
        .lvl_wprot (lvl_wprot),
        .lvl_busy  (lvl_busy),
        .irq       (irq)
    );

    // vector: {is_read, addr[8:0], data[15:0], tag number}
    typedef struct packed {
        logic        is_read;
        logic [8:0]  addr;
        logic [15:0] data;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 17;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 9'h01C, 16'h0000, 4'd1},
        '{1'b1, 9'h01E, 16'h0000, 4'd1},
        '{1'b1, 9'h020, 16'h031D, 4'd1},
        '{1'b1, 9'h022, 16'h837F, 4'd1},
        '{1'b1, 9'h036, 16'h0000, 4'd1},
        '{1'b1, 9'h038, 16'hC007, 4'd1},
        '{1'b0, 9'h020, 16'h1234, 4'd6},
        '{1'b1, 9'h020, 16'h1234, 4'd6},
        '{1'b1, 9'h022, 16'h837F, 4'd6},
        '{1'b0, 9'h022, 16'hA5A5, 4'd6},
        '{1'b1, 9'h022, 16'hA5A5, 4'd6},
        '{1'b1, 9'h020, 16'h1234, 4'd6},
        '{1'b0, 9'h038, 16'h0F0F, 4'd8},
        '{1'b1, 9'h038, 16'h0F0F, 4'd8},
        '{1'b0, 9'h024, 16'hFFFF, 4'd9},
        '{1'b1, 9'h024, 16'h0000, 4'd9},
        '{1'b1, 9'h000, 16'h0000, 4'd9}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [8:0] a, input logic [15:0] exp);
        reg_addr = a;
        #1;
        check(tag, {16'h0, reg_rdata}, {16'h0, exp});
    endtask

    task automatic pulse_main(input logic [31:0] v);
        @(negedge clk);
        main_evt = v;
        @(negedge clk);
        main_evt = '0;
    endtask

    task automatic pulse_io(input logic [15:0] v);
        @(negedge clk);
        io_evt = v;
        @(negedge clk);
        io_evt = '0;
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #400000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        wait_cyc(3);
        check("R1 irq at reset", {31'h0, irq}, 32'h0);
        rst_n = 1'b1;
        wait_cyc(1);

        // table walk: reset values, mask halves, unmapped offsets
        for (int i = 0; i < NVEC; i++) begin
            if (VECS[i].is_read)
                rd($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].addr, VECS[i].data);
            else
                wr(VECS[i].addr, VECS[i].data);
        end
        check("R1 irq idle after table", {31'h0, irq}, 32'h0);

        // mask everything for the status tests
        wr(9'h020, 16'hFFFF);
        wr(9'h022, 16'hFFFF);
        wr(9'h038, 16'hFFFF);

        // R2: sticky set, read does not clear
        pulse_main(32'h0100_0005);
        rd("R2 low half after set", 9'h01C, 16'h0005);
        rd("R2 high half after set", 9'h01E, 16'h0100);
        rd("R2 low half second read", 9'h01C, 16'h0005);
        wait_cyc(2);
        rd("R2 still set later", 9'h01E, 16'h0100);

        // R10: only implemented sticky bits respond
        pulse_main(32'hFFFF_FFFF);
        rd("R10 low half all events", 9'h01C, 16'h001D);
        rd("R10 high half all events", 9'h01E, 16'hA37F);

        // R3: write-0-clears, half isolation
        wr(9'h01C, 16'hFFFB);
        rd("R3 clear bit2 only", 9'h01C, 16'h0019);
        rd("R3 high half untouched", 9'h01E, 16'hA37F);
        wr(9'h01E, 16'h0000);
        rd("R3 high half cleared", 9'h01E, 16'h0000);
        rd("R3 low half untouched", 9'h01C, 16'h0019);
        wr(9'h01C, 16'hFFFF);
        rd("R3 all-ones write no change", 9'h01C, 16'h0019);

        // R4: set and clear in the same cycle
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 9'h01C; reg_wdata = 16'h0000; main_evt = 32'h0000_0008;
        @(negedge clk);
        reg_wr = 1'b0; main_evt = '0;
        rd("R4 set wins over clear", 9'h01C, 16'h0008);
        wr(9'h01C, 16'h0000);
        rd("R4 later clear works", 9'h01C, 16'h0000);

        // R5: level bits
        lvl_sig = 1'b1; lvl_wprot = 1'b1; lvl_busy = 1'b1;
        rd("R5 levels low half", 9'h01C, 16'h00A0);
        rd("R5 level high half", 9'h01E, 16'h4000);
        wr(9'h01C, 16'h0000);
        wr(9'h01E, 16'h0000);
        rd("R5 write ignored low", 9'h01C, 16'h00A0);
        rd("R5 write ignored high", 9'h01E, 16'h4000);
        lvl_sig = 1'b0; lvl_wprot = 1'b0; lvl_busy = 1'b0;
        rd("R5 levels dropped low", 9'h01C, 16'h0000);
        rd("R5 levels dropped high", 9'h01E, 16'h0000);

        // R7: irq latency on a sticky source
        wr(9'h020, 16'hFFFE);
        check("R7 no irq before event", {31'h0, irq}, 32'h0);
        pulse_main(32'h0000_0001);
        check("R7 irq not yet one edge", {31'h0, irq}, 32'h0);
        @(negedge clk);
        check("R7 irq raised", {31'h0, irq}, 32'h1);
        wr(9'h01C, 16'hFFFE);
        check("R7 irq still high after clear edge", {31'h0, irq}, 32'h1);
        @(negedge clk);
        check("R7 irq dropped", {31'h0, irq}, 32'h0);

        // R7: masked source does not interrupt
        pulse_main(32'h0000_0004);
        wait_cyc(2);
        check("R7 masked source quiet", {31'h0, irq}, 32'h0);
        wr(9'h01C, 16'h0000);

        // R7: level source through the high-half mask
        wr(9'h022, 16'hBFFF);
        lvl_busy = 1'b1;
        wait_cyc(2);
        check("R7 level irq raised", {31'h0, irq}, 32'h1);
        lvl_busy = 1'b0;
        wait_cyc(2);
        check("R7 level irq dropped", {31'h0, irq}, 32'h0);
        wr(9'h022, 16'hFFFF);

        // R8: card I/O pair
        pulse_io(16'hFFFF);
        rd("R8 io implemented bits", 9'h036, 16'hC007);
        wr(9'h036, 16'hFFFE);
        rd("R8 io clear bit0", 9'h036, 16'hC006);
        check("R8 io masked quiet", {31'h0, irq}, 32'h0);
        wr(9'h038, 16'hFFFB);
        wait_cyc(1);
        check("R8 io unmasked irq", {31'h0, irq}, 32'h1);
        wr(9'h036, 16'h0000);
        wait_cyc(1);
        check("R8 io cleared irq low", {31'h0, irq}, 32'h0);
        rd("R8 io status zero", 9'h036, 16'h0000);

        // R9: unmapped write leaves mapped registers alone
        wr(9'h03A, 16'h0000);
        rd("R9 io mask unchanged", 9'h038, 16'hFFFB);
        rd("R9 main mask unchanged", 9'h020, 16'hFFFE);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule